// File: doc/BRIEF.md
# Matched-Filter Pulse Arrival-Time Estimator

This block sits on one digitised detector channel. It estimates when a pulse arrived, with a resolution finer than the sample period. Each accepted sample enters an eight-tap correlator that holds a programmable copy of the expected pulse shape. The template spans the whole pulse, falling tail included, so both edges add timing information. The correlator output is close to symmetric around the arrival point.

A coarse peak search runs on that output and is gated by a programmable threshold. Around each qualified peak, a three-point interpolator is evaluated at eight equally spaced fractional positions, and the strongest position is taken. The result is emitted as a fine timestamp: the coarse sample timestamp counted in eighths of a sample, plus the chosen fractional offset. Software loads the template while the channel is stopped (`run_i` low). While `run_i` is high, the block processes samples.

Top module: `mfte_top`

## Requirements
- R1: After reset all template taps are zero and `fine_valid_o` is low. While `run_i` is low `fine_valid_o` stays low from the next cycle on.
- R2: For each accepted sample (`sample_valid_i` and `run_i` high) the correlation is y[n] = sum over k=0..7 of tap[k]*x[n-k]. Samples and taps are two's complement. Samples from before the current run (before `run_i` last rose) count as zero.
- R3: A coarse peak is found at sample n when y[n-1] < y[n] >= y[n+1] and y[n] > `thr_i` (signed compare). All three values must come from the same run.
- R4: After a peak, no further peak is accepted until a correlation value <= `thr_i` arrives. The value y[n+1] that confirms the peak already counts for this re-arm.
- R5: For phase offsets p = -4..+3 (eighths of a sample), the interpolator computes v(p) = p(p-8)*y[n-1] + (128-2p^2)*y[n] + p(p+8)*y[n+1]. It picks the p with the largest v, and ties go to the most negative p.
- R6: `fine_ts_o` = ts[n]*8 + p modulo 2^(TS_W+3), where ts[n] is the `ts_i` value that came with sample n.
- R7: `fine_valid_o` pulses for one cycle, exactly 3 clock cycles after the edge that accepts sample n+1. Idle cycles between samples do not change any result.
- R8: When `tap_we_i` is high and `run_i` is low, `tap_data_i` is written to tap number `tap_addr_i` (tap k weights x[n-k]). A write attempted while `run_i` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| run_i | input | 1 | high: process samples; low: clear history, allow template writes |
| sample_valid_i | input | 1 | sample strobe |
| sample_i | input | SAMPLE_W | signed sample |
| ts_i | input | TS_W | coarse timestamp of the current sample |
| thr_i | input | SAMPLE_W+TAP_W+log2(NTAPS) | signed detection threshold on correlation output |
| tap_we_i | input | 1 | template write strobe |
| tap_addr_i | input | log2(NTAPS) | template tap index |
| tap_data_i | input | TAP_W | signed tap value |
| fine_valid_o | output | 1 | fine timestamp valid pulse |
| fine_ts_o | output | TS_W+log2(UPS) | fine timestamp in 1/UPS sample units |

## Verification
Peak qualification and threshold re-arm can fall in the same cycle. This happens when the sample that confirms a peak also lies at or below the threshold. The bench provokes it with a correlation that alternates between 0 and 100 on consecutive strobes, so peaks sit two samples apart. It then requires a fine timestamp for every peak, each exactly two cycles after the previous one. A companion sequence keeps the dip above the threshold and expects the second bump to be suppressed. Expected timestamps and cycles come from a plain arithmetic model of the correlation, peak rule and interpolation.

// File: rtl/mfte_pkg.sv
package mfte_pkg;
  // three-point interpolation weights at offset p/u, scaled by 2*u*u
  function automatic int coef_lo(int p, int u);
    return p * (p - u);
  endfunction
  function automatic int coef_mid(int p, int u);
    return 2 * u * u - 2 * p * p;
  endfunction
  function automatic int coef_hi(int p, int u);
    return p * (p + u);
  endfunction
endpackage

// File: rtl/mfte_taps.sv
module mfte_taps #(
  parameter int NTAPS = 8,
  parameter int TAP_W = 8,
  localparam int ADDR_W = $clog2(NTAPS)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         run_i,
  input  logic                         tap_we_i,
  input  logic [ADDR_W-1:0]            tap_addr_i,
  input  logic [TAP_W-1:0]             tap_data_i,
  output logic [NTAPS-1:0][TAP_W-1:0]  taps_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_o <= '0;
    end else if (tap_we_i && !run_i) begin
      for (int k = 0; k < NTAPS; k++)
        if (tap_addr_i == ADDR_W'(k)) taps_o[k] <= tap_data_i;
    end
  end
endmodule

// File: rtl/mfte_corr.sv
module mfte_corr #(
  parameter int SAMPLE_W = 12,
  parameter int TAP_W    = 8,
  parameter int NTAPS    = 8,
  parameter int TS_W     = 32,
  parameter int Y_W      = 23
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          run_i,
  input  logic                          valid_i,
  input  logic signed [SAMPLE_W-1:0]    sample_i,
  input  logic [TS_W-1:0]               ts_i,
  input  logic [NTAPS-1:0][TAP_W-1:0]   taps_i,
  output logic                          valid_o,
  output logic signed [Y_W-1:0]         y_o,
  output logic [TS_W-1:0]               ts_o
);
  logic signed [SAMPLE_W-1:0] hist_q [NTAPS-1];
  logic signed [SAMPLE_W-1:0] win    [NTAPS];
  logic signed [Y_W-1:0]      acc;

  always_comb begin
    win[0] = sample_i;
    for (int k = 1; k < NTAPS; k++) win[k] = hist_q[k-1];
    acc = '0;
    for (int k = 0; k < NTAPS; k++)
      acc = acc + Y_W'($signed(taps_i[k])) * Y_W'(win[k]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAPS-1; k++) hist_q[k] <= '0;
      valid_o <= 1'b0;
      y_o     <= '0;
      ts_o    <= '0;
    end else begin
      valid_o <= valid_i && run_i;
      if (!run_i) begin
        for (int k = 0; k < NTAPS-1; k++) hist_q[k] <= '0;
      end else if (valid_i) begin
        hist_q[0] <= sample_i;
        for (int k = 1; k < NTAPS-1; k++) hist_q[k] <= hist_q[k-1];
        y_o  <= acc;
        ts_o <= ts_i;
      end
    end
  end
endmodule

// File: rtl/mfte_peak.sv
module mfte_peak #(
  parameter int Y_W  = 23,
  parameter int TS_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic                   valid_i,
  input  logic signed [Y_W-1:0]  y_i,
  input  logic [TS_W-1:0]        ts_i,
  input  logic signed [Y_W-1:0]  thr_i,
  output logic                   pk_valid_o,
  output logic signed [Y_W-1:0]  pk_prev_o,
  output logic signed [Y_W-1:0]  pk_mid_o,
  output logic signed [Y_W-1:0]  pk_next_o,
  output logic [TS_W-1:0]        pk_ts_o
);
  logic signed [Y_W-1:0] y1_q, y0_q;  // y1 older, y0 newer
  logic [TS_W-1:0]       t0_q;
  logic [1:0]            cnt_q;
  logic                  armed_q;
  logic                  det;

  assign det = valid_i && (cnt_q == 2'd2) && armed_q &&
               (y1_q < y0_q) && (y0_q >= y_i) && (y0_q > thr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y1_q <= '0; y0_q <= '0; t0_q <= '0;
      cnt_q <= '0; armed_q <= 1'b1;
      pk_valid_o <= 1'b0;
      pk_prev_o <= '0; pk_mid_o <= '0; pk_next_o <= '0; pk_ts_o <= '0;
    end else if (!run_i) begin
      cnt_q <= '0;
      armed_q <= 1'b1;
      pk_valid_o <= 1'b0;
    end else begin
      pk_valid_o <= det;
      if (valid_i) begin
        y1_q <= y0_q;
        y0_q <= y_i;
        t0_q <= ts_i;
        if (cnt_q != 2'd2) cnt_q <= cnt_q + 2'd1;
        // a value at/below threshold re-arms, even the one confirming this peak
        armed_q <= (y_i <= thr_i) ? 1'b1 : (det ? 1'b0 : armed_q);
      end
      if (det) begin
        pk_prev_o <= y1_q;
        pk_mid_o  <= y0_q;
        pk_next_o <= y_i;
        pk_ts_o   <= t0_q;
      end
    end
  end
endmodule

// File: rtl/mfte_interp.sv
module mfte_interp #(
  parameter int Y_W  = 23,
  parameter int TS_W = 32,
  parameter int UPS  = 8,
  localparam int FRAC_W = $clog2(UPS),
  localparam int C_W    = $clog2(2*UPS*UPS) + 2,
  localparam int V_W    = Y_W + C_W + 2,
  localparam int OUT_W  = TS_W + FRAC_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   run_i,
  input  logic                   valid_i,
  input  logic signed [Y_W-1:0]  prev_i,
  input  logic signed [Y_W-1:0]  mid_i,
  input  logic signed [Y_W-1:0]  next_i,
  input  logic [TS_W-1:0]        ts_i,
  output logic                   valid_o,
  output logic [OUT_W-1:0]       fine_ts_o
);
  logic signed [V_W-1:0] vals_d [UPS];
  logic signed [V_W-1:0] vals_q [UPS];
  logic [TS_W-1:0]       ts_a_q;
  logic                  a_valid_q;

  for (genvar i = 0; i < UPS; i++) begin : g_phase
    localparam int P = i - UPS/2;
    localparam logic signed [V_W-1:0] CL = V_W'(mfte_pkg::coef_lo(P, UPS));
    localparam logic signed [V_W-1:0] CM = V_W'(mfte_pkg::coef_mid(P, UPS));
    localparam logic signed [V_W-1:0] CH = V_W'(mfte_pkg::coef_hi(P, UPS));
    assign vals_d[i] = CL * V_W'(prev_i) + CM * V_W'(mid_i) + CH * V_W'(next_i);
  end

  logic signed [V_W-1:0] best_v;
  logic [FRAC_W-1:0]     best_idx;
  logic [OUT_W-1:0]      fine_d;

  always_comb begin
    best_v   = vals_q[0];
    best_idx = '0;
    for (int i = 1; i < UPS; i++)
      if (vals_q[i] > best_v) begin  // strict: ties keep the earlier phase
        best_v   = vals_q[i];
        best_idx = FRAC_W'(i);
      end
    fine_d = {ts_a_q, {FRAC_W{1'b0}}} + OUT_W'(best_idx) - OUT_W'(UPS/2);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < UPS; i++) vals_q[i] <= '0;
      ts_a_q    <= '0;
      a_valid_q <= 1'b0;
      valid_o   <= 1'b0;
      fine_ts_o <= '0;
    end else begin
      a_valid_q <= valid_i && run_i;
      valid_o   <= a_valid_q && run_i;
      if (valid_i) begin
        for (int i = 0; i < UPS; i++) vals_q[i] <= vals_d[i];
        ts_a_q <= ts_i;
      end
      if (a_valid_q) fine_ts_o <= fine_d;
    end
  end
endmodule

// File: rtl/mfte_top.sv
module mfte_top #(
  parameter int SAMPLE_W = 12,
  parameter int TAP_W    = 8,
  parameter int NTAPS    = 8,
  parameter int TS_W     = 32,
  parameter int UPS      = 8,
  localparam int Y_W     = SAMPLE_W + TAP_W + $clog2(NTAPS),
  localparam int ADDR_W  = $clog2(NTAPS),
  localparam int FRAC_W  = $clog2(UPS)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        run_i,
  input  logic                        sample_valid_i,
  input  logic signed [SAMPLE_W-1:0]  sample_i,
  input  logic [TS_W-1:0]             ts_i,
  input  logic signed [Y_W-1:0]       thr_i,
  input  logic                        tap_we_i,
  input  logic [ADDR_W-1:0]           tap_addr_i,
  input  logic [TAP_W-1:0]            tap_data_i,
  output logic                        fine_valid_o,
  output logic [TS_W+FRAC_W-1:0]      fine_ts_o
);
  logic [NTAPS-1:0][TAP_W-1:0] taps_q;
  logic                        corr_valid;
  logic signed [Y_W-1:0]       corr_y;
  logic [TS_W-1:0]             corr_ts;
  logic                        pk_valid;
  logic signed [Y_W-1:0]       pk_prev, pk_mid, pk_next;
  logic [TS_W-1:0]             pk_ts;

  mfte_taps #(.NTAPS(NTAPS), .TAP_W(TAP_W)) i_taps (
    .clk_i, .rst_ni, .run_i, .tap_we_i, .tap_addr_i, .tap_data_i,
    .taps_o(taps_q)
  );

  mfte_corr #(.SAMPLE_W(SAMPLE_W), .TAP_W(TAP_W), .NTAPS(NTAPS), .TS_W(TS_W), .Y_W(Y_W)) i_corr (
    .clk_i, .rst_ni, .run_i,
    .valid_i(sample_valid_i), .sample_i, .ts_i, .taps_i(taps_q),
    .valid_o(corr_valid), .y_o(corr_y), .ts_o(corr_ts)
  );

  mfte_peak #(.Y_W(Y_W), .TS_W(TS_W)) i_peak (
    .clk_i, .rst_ni, .run_i,
    .valid_i(corr_valid), .y_i(corr_y), .ts_i(corr_ts), .thr_i,
    .pk_valid_o(pk_valid), .pk_prev_o(pk_prev), .pk_mid_o(pk_mid),
    .pk_next_o(pk_next), .pk_ts_o(pk_ts)
  );

  mfte_interp #(.Y_W(Y_W), .TS_W(TS_W), .UPS(UPS)) i_interp (
    .clk_i, .rst_ni, .run_i,
    .valid_i(pk_valid), .prev_i(pk_prev), .mid_i(pk_mid), .next_i(pk_next), .ts_i(pk_ts),
    .valid_o(fine_valid_o), .fine_ts_o
  );
endmodule

// File: rtl/mfte_chk.sv
module mfte_chk #(
  parameter int NTAPS = 8,
  parameter int TAP_W = 8,
  parameter int Y_W   = 23
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        run_i,
  input logic                        sample_valid_i,
  input logic signed [Y_W-1:0]       thr_i,
  input logic                        fine_valid_o,
  input logic [NTAPS-1:0][TAP_W-1:0] taps_q,
  input logic                        pk_valid,
  input logic signed [Y_W-1:0]       pk_mid
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !fine_valid_o);

  assert_peak_above_thr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_valid |-> (pk_mid > $past(thr_i)));

  assert_peak_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_valid |=> !pk_valid);

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_valid_o |=> !fine_valid_o);

  assert_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fine_valid_o |-> $past(sample_valid_i && run_i, 4));

  assert_taps_frozen_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |=> $stable(taps_q));
endmodule

bind mfte_top mfte_chk #(.NTAPS(NTAPS), .TAP_W(TAP_W), .Y_W(Y_W)) i_mfte_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .sample_valid_i(sample_valid_i),
  .thr_i(thr_i), .fine_valid_o(fine_valid_o), .taps_q(taps_q),
  .pk_valid(pk_valid), .pk_mid(pk_mid)
);

// File: tb/test_mfte_top.sv
`timescale 1ns/1ps
module test_mfte_top;
  localparam int SAMPLE_W = 12;
  localparam int TAP_W    = 8;
  localparam int NTAPS    = 8;
  localparam int TS_W     = 32;
  localparam int UPS      = 8;
  localparam int Y_W      = SAMPLE_W + TAP_W + $clog2(NTAPS);
  localparam int OUT_W    = TS_W + 3;
  localparam longint OUT_MASK = (longint'(1) << OUT_W) - 1;
  localparam longint TS_MASK  = (longint'(1) << TS_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0, sv = 1'b0, twe = 1'b0;
  logic signed [SAMPLE_W-1:0] smp = '0;
  logic [TS_W-1:0] ts = '0;
  logic signed [Y_W-1:0] thr = '0;
  logic [2:0] taddr = '0;
  logic [TAP_W-1:0] tdata = '0;
  logic fv;
  logic [OUT_W-1:0] fts;

  mfte_top i_mfte_top (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .sample_valid_i(sv), .sample_i(smp),
    .ts_i(ts), .thr_i(thr), .tap_we_i(twe), .tap_addr_i(taddr), .tap_data_i(tdata),
    .fine_valid_o(fv), .fine_ts_o(fts)
  );

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0;
  int tb_tap[NTAPS];
  int xq[$];
  int got_n = 0;
  longint got_ts[64];
  int got_cyc[64];

  always @(negedge clk) if (fv) begin
    if (got_n < 64) begin got_ts[got_n] = longint'(fts); got_cyc[got_n] = cyc; end
    got_n++;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_tap(input int a, input int v);
    @(negedge clk);
    twe = 1'b1; taddr = 3'(a); tdata = TAP_W'(v);
    @(negedge clk);
    twe = 1'b0;
    if (!run) tb_tap[a] = v;  // writes while running are ignored (R8)
  endtask

  task automatic set_taps(input int t0, t1, t2, t3, t4, t5, t6, t7);
    write_tap(0, t0); write_tap(1, t1); write_tap(2, t2); write_tap(3, t3);
    write_tap(4, t4); write_tap(5, t5); write_tap(6, t6); write_tap(7, t7);
  endtask

  // drive xq, model R2..R7, compare
  task automatic run_seq(input string req, input int thr_v, input longint ts0,
                         input int gap, input bit wr_in_run);
    int cap[64];
    longint y[64];
    longint exp_ts[64];
    int exp_cyc[64];
    int exp_n = 0;
    bit armed = 1'b1;
    int nx = xq.size();
    thr = Y_W'(thr_v);
    @(negedge clk);
    run = 1'b1;
    got_n = 0;
    if (wr_in_run) write_tap(0, 100);
    for (int i = 0; i < nx; i++) begin
      @(negedge clk);
      sv = 1'b1; smp = SAMPLE_W'(xq[i]); ts = TS_W'(ts0 + i);
      cap[i] = cyc + 1;
      for (int g = 0; g < gap; g++) begin @(negedge clk); sv = 1'b0; end
    end
    @(negedge clk); sv = 1'b0;
    repeat (8) @(negedge clk);
    run = 1'b0;
    for (int j = 0; j < nx; j++) begin
      bit det;
      y[j] = 0;
      for (int k = 0; k < NTAPS; k++) if (j - k >= 0) y[j] += longint'(tb_tap[k]) * xq[j-k];
      det = (j >= 2) && armed && (y[j-2] < y[j-1]) && (y[j-1] >= y[j]) && (y[j-1] > thr_v);
      if (det) begin
        longint bv = 0;
        int bp = 0;
        for (int i = 0; i < UPS; i++) begin
          int p = i - UPS/2;
          longint v = longint'(p*(p-8))*y[j-2] + longint'(128-2*p*p)*y[j-1] + longint'(p*(p+8))*y[j];
          if (i == 0 || v > bv) begin bv = v; bp = p; end
        end
        exp_ts[exp_n]  = ((((ts0 + j - 1) & TS_MASK) * 8) + bp) & OUT_MASK;
        exp_cyc[exp_n] = cap[j] + 3;
        exp_n++;
      end
      armed = (y[j] <= thr_v) ? 1'b1 : (det ? 1'b0 : armed);
    end
    check(got_n == exp_n, {req, " count"}, got_n, exp_n);
    for (int e = 0; e < exp_n && e < got_n && e < 64; e++) begin
      check(got_ts[e] == exp_ts[e], {req, " fine ts"}, got_ts[e], exp_ts[e]);
      check(got_cyc[e] == exp_cyc[e], {req, " R7 latency"}, got_cyc[e], exp_cyc[e]);
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < NTAPS; k++) tb_tap[k] = 0;
    repeat (3) @(negedge clk);
    check(fv == 1'b0, "R1 output low in reset", fv, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(fv == 1'b0, "R1 output low after reset", fv, 0);

    // R1: taps zero after reset -> flat correlation, no peaks
    xq = '{5, 50, 5, 90, 3, 70, 1};
    run_seq("R1 zero taps", -10, 10, 0, 1'b0);

    // R8: single identity tap
    set_taps(1, 0, 0, 0, 0, 0, 0, 0);
    xq = '{0, 0, 10, 40, 50, 40, 10, 0, 0, 0};
    run_seq("R5 symmetric", 20, 100, 0, 1'b0);
    xq = '{0, 5, 30, 50, 45, 5, 0};
    run_seq("R5 right lean", 20, 200, 0, 1'b0);
    xq = '{0, 50, 50, 0, 0};
    run_seq("R5 equal right neighbour", 20, 300, 0, 1'b0);
    // R6: coarse ts 0 with negative offset wraps
    xq = '{45, 50, 10, 0};
    run_seq("R6 wrap", 20, -1, 0, 1'b0);
    // R3: threshold strictly exceeded
    xq = '{0, 20, 50, 20, 0};
    run_seq("R3 equal thr", 50, 400, 0, 1'b0);
    run_seq("R3 below thr", 49, 400, 0, 1'b0);
    // R4: dip stays above thr -> second bump inhibited; lower dip re-arms
    xq = '{0, 30, 60, 40, 55, 70, 30, 0};
    run_seq("R4 inhibit", 20, 500, 0, 1'b0);
    run_seq("R4 rearm", 45, 500, 0, 1'b0);
    // R4/R7: detection and re-arm in the same cycle, back-to-back strobes
    xq = '{0, 100, 0, 100, 0, 100, 0};
    run_seq("R4 alternating", 50, 600, 0, 1'b0);
    // R7: idle gaps between strobes
    xq = '{0, 5, 30, 50, 45, 5, 0};
    run_seq("R7 gaps", 20, 200, 3, 1'b0);
    // R2: signed taps and samples
    set_taps(-1, 0, 0, 0, 0, 0, 0, 0);
    xq = '{0, -10, -40, -50, -30, -10, 0};
    run_seq("R2 negative", 20, 700, 0, 1'b0);
    // R2: full template, tail with a negative tap; ends on large samples
    set_taps(2, 5, 8, 7, 5, 3, 1, -2);
    xq = '{0, 0, 0, 20, 60, 100, 80, 50, 30, 15, 5, 0, 0, 0, 0, 0, 0, 0, 0, 0, 300, 300, 300};
    run_seq("R2 template", 500, 800, 0, 1'b0);
    // R2 history cleared between runs; R8 write during run ignored
    xq = '{20, 60, 100, 80, 50, 30, 15, 5, 0, 0, 0, 0, 0, 0, 0, 0};
    run_seq("R8 write ignored", 500, 900, 1, 1'b1);
    check(tb_tap[0] == 2, "R8 model tap kept", tb_tap[0], 2);
    run_seq("R2 restart", 500, 950, 0, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule